// File: doc/BRIEF.md
# Queue-Ordered Operand Cache with Run-Ahead Prefetch

This block is a small operand cache for a compute engine whose sequence of line reads is fixed before the work starts. The address stream enters on one handshake port. A prefetch stage takes each address, looks for a resident line holding it, and either joins that line or claims a free line and issues one read to backing memory. Every accepted address is appended, as a line index, to an ordered queue. The fetch side drains that queue in the same order, a number of entries behind, and delivers the tag and data of each line.

Each resident line carries a count of queued uses that have not been consumed yet. The line is returned to the free pool in the same cycle that its last queued use leaves the fetch port, so replacement follows the known future of the stream. Nothing is guessed. How far the prefetch stage may run ahead is bounded by a programmable lead and by the number of lines that can be claimed. Backing reads may complete in any order, because each response names the line it fills. A one-cycle clear discards the whole queue and every resident line, and starts a new stream.

Top module: `opq_cache`

## Requirements
- R1: After reset, and in the cycle following a clear, `fetch_valid_o` is 0 and `miss_count_o` is 0. `fetch_valid_o` and `req_ready_o` are also forced to 0 during any cycle in which `clear_i` is 1.
- R2: Fetches come out in exactly the order in which the addresses were accepted. `fetch_addr_o` gives the accepted address. `fetch_data_o` gives the data that the backing response returned for the line holding that address.
- R3: When an accepted address has no resident line, exactly one backing read is issued in the same cycle. Its `mem_req_addr_o` is that address and its `mem_req_line_o` is a line that is neither resident nor waiting on a read. The address is accepted only while `mem_req_ready_i` is 1.
- R4: When an address matches a resident line (filled or still pending), it is accepted without a backing read, whatever the value of `mem_req_ready_i`.
- R5: The number of entries that are accepted but not yet fetched never exceeds min(`lead_i`, MAX_LEAD). A `lead_i` value of 0 blocks all new acceptance, and values above MAX_LEAD act as MAX_LEAD.
- R6: An address that has no resident line is not accepted while every line is resident or waiting on a read.
- R7: A line is released only when its last queued use is fetched. If the same address is requested after that release, a new backing read is issued.
- R8: Responses may arrive in any order, and each fills the line named by `mem_rsp_line_i`. `fetch_valid_o` rises only once the line at the head of the queue is filled.
- R9: `miss_count_o` goes up by exactly one for each queue entry that sits at the head, unfilled, while `fetch_ready_i` is 1. It never goes up more than once for the same entry.
- R10: While `fetch_valid_o` is 1 and `fetch_ready_i` is 0, the fetch outputs hold their values in the next cycle unless a clear occurs.
- R11: A clear empties the queue and all resident lines. A read issued before the clear keeps its line out of use until that read's response arrives, and the response never fills a line for the new stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear that starts a new stream |
| lead_i | input | LEAD_W | Largest allowed number of entries accepted but not yet fetched |
| req_valid_i | input | 1 | A stream address is offered |
| req_addr_i | input | ADDR_W | Line address offered |
| req_ready_o | output | 1 | The address is accepted this cycle |
| mem_req_valid_o | output | 1 | A backing read is offered |
| mem_req_addr_o | output | ADDR_W | Address of the backing read |
| mem_req_line_o | output | LINE_W | Line that the read will fill |
| mem_req_ready_i | input | 1 | Backing memory takes the read |
| mem_rsp_valid_i | input | 1 | Read data is returning |
| mem_rsp_line_i | input | LINE_W | Line the returning data fills |
| mem_rsp_data_i | input | DATA_W | Returned line data |
| fetch_valid_o | output | 1 | The head entry is available |
| fetch_addr_o | output | ADDR_W | Address of the head entry |
| fetch_data_o | output | DATA_W | Data of the head entry |
| fetch_ready_i | input | 1 | Consumer takes the head entry |
| miss_count_o | output | MISS_W | Number of fetch-side misses since reset or clear |

## Verification
A use count that is off by one shows up on the ports in two ways. If it is too low, a line is released early: the next request for that address issues a second backing read, or a later fetch returns data or a tag that belongs to another address. If it is too high, the line is never released, so `req_ready_o` drops sooner than the free-line limit allows. A line index that is wrong or corrupt in the queue becomes visible on the fetch port as soon as that entry reaches the head. A lost fill state shows as `fetch_valid_o` staying low after its response, together with an extra miss count. Because the bench model predicts the value of every output in every cycle, a divergence is reported in the first cycle in which it reaches a port.

// File: rtl/opq_pkg.sv
package opq_pkg;
  typedef enum logic [1:0] {
    LS_FREE = 2'd0,
    LS_PEND = 2'd1,
    LS_FULL = 2'd2
  } line_st_e;
endpackage

// File: rtl/opq_order_queue.sv
module opq_order_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wrap_inc(wr_q);
      if (pop_i)  rd_q <= wrap_inc(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) slot_q[wr_q] <= din_i;
  end

  assign dout_o  = slot_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !clear_i) |-> (cnt_q < CW'(DEPTH))); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0)); // R2
endmodule

// File: rtl/opq_line_table.sv
module opq_line_table
  import opq_pkg::*;
#(
  parameter int LINES  = 6,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int USE_W  = 4,
  localparam int IW    = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic              hit_o,
  output logic [IW-1:0]     hit_idx_o,
  output logic              free_ok_o,
  output logic [IW-1:0]     free_idx_o,
  input  logic              alloc_i,
  input  logic              merge_i,
  input  logic              release_i,
  input  logic [IW-1:0]     rel_idx_i,
  input  logic              rsp_valid_i,
  input  logic [IW-1:0]     rsp_idx_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic              rd_filled_o,
  output logic [ADDR_W-1:0] rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  line_st_e          st_q   [LINES];
  logic [ADDR_W-1:0] tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [USE_W-1:0]  use_q  [LINES];
  logic [LINES-1:0]  busy_q;

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!hit_o && st_q[i] != LS_FREE && tag_q[i] == look_addr_i) begin
        hit_o     = 1'b1;
        hit_idx_o = IW'(i);
      end
    end
  end

  always_comb begin
    free_ok_o  = 1'b0;
    free_idx_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!free_ok_o && st_q[i] == LS_FREE && !busy_q[i]) begin
        free_ok_o  = 1'b1;
        free_idx_o = IW'(i);
      end
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             take, inc, dec, fill;
    logic [USE_W-1:0] use_nxt;

    assign take    = alloc_i && (free_idx_o == IW'(g));
    assign inc     = merge_i && (hit_idx_o == IW'(g));
    assign dec     = release_i && (rel_idx_i == IW'(g));
    assign fill    = rsp_valid_i && (rsp_idx_i == IW'(g));
    assign use_nxt = use_q[g] + USE_W'(inc) - USE_W'(dec);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g]   <= LS_FREE;
        use_q[g]  <= '0;
        tag_q[g]  <= '0;
        busy_q[g] <= 1'b0;
      end else begin
        if (take)      busy_q[g] <= 1'b1;
        else if (fill) busy_q[g] <= 1'b0;

        if (clear_i) begin
          st_q[g]  <= LS_FREE;
          use_q[g] <= '0;
        end else if (take) begin
          st_q[g]  <= LS_PEND;
          tag_q[g] <= look_addr_i;
          use_q[g] <= USE_W'(1);
        end else begin
          use_q[g] <= use_nxt;
          if (st_q[g] != LS_FREE && use_nxt == '0) st_q[g] <= LS_FREE;
          else if (fill && st_q[g] == LS_PEND)     st_q[g] <= LS_FULL;
        end
      end
    end

    always_ff @(posedge clk_i) begin
      if (fill && st_q[g] == LS_PEND && !clear_i) data_q[g] <= rsp_data_i;
    end

    AST_HELD_HAS_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[g] != LS_FREE) |-> (use_q[g] != '0)); // R7
  end

  assign rd_filled_o = (st_q[rd_idx_i] == LS_FULL);
  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_data_o   = data_q[rd_idx_i];

  AST_NO_ALLOC_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_i && hit_o)); // R4
  AST_RSP_EXPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> busy_q[rsp_idx_i]); // R8
  AST_RELEASE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && !clear_i) |-> (st_q[rel_idx_i] == LS_FULL)); // R7
endmodule

// File: rtl/opq_cache.sv
module opq_cache
  import opq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int LINES    = 6,
  parameter int MAX_LEAD = 8,
  parameter int MISS_W   = 16,
  localparam int LINE_W  = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int LEAD_W  = $clog2(MAX_LEAD + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [LEAD_W-1:0] lead_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              mem_req_valid_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [LINE_W-1:0] mem_req_line_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [LINE_W-1:0] mem_rsp_line_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  output logic              fetch_valid_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [DATA_W-1:0] fetch_data_o,
  input  logic              fetch_ready_i,
  output logic [MISS_W-1:0] miss_count_o
);
  logic [LEAD_W-1:0] eff_lead, q_count;
  logic              room, hit, free_ok, take_miss, take_merge, push, pop;
  logic              q_empty, head_filled;
  logic [LINE_W-1:0] hit_idx, free_idx, head_idx;
  logic [MISS_W-1:0] miss_q;
  logic              counted_q;

  assign eff_lead = (lead_i > LEAD_W'(MAX_LEAD)) ? LEAD_W'(MAX_LEAD) : lead_i;
  assign room     = (q_count < eff_lead) && !clear_i;

  assign mem_req_valid_o = req_valid_i && room && !hit && free_ok;
  assign mem_req_addr_o  = req_addr_i;
  assign mem_req_line_o  = free_idx;
  assign take_miss       = mem_req_valid_o && mem_req_ready_i;
  assign take_merge      = req_valid_i && room && hit;
  assign req_ready_o     = room && (hit || (free_ok && mem_req_ready_i));
  assign push            = take_miss || take_merge;

  assign fetch_valid_o = !q_empty && head_filled && !clear_i;
  assign pop           = fetch_valid_o && fetch_ready_i;

  opq_line_table #(
    .LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .USE_W(LEAD_W)
  ) u_lines (
    .clk_i, .rst_ni, .clear_i,
    .look_addr_i (req_addr_i),
    .hit_o       (hit),
    .hit_idx_o   (hit_idx),
    .free_ok_o   (free_ok),
    .free_idx_o  (free_idx),
    .alloc_i     (take_miss),
    .merge_i     (take_merge),
    .release_i   (pop),
    .rel_idx_i   (head_idx),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_idx_i   (mem_rsp_line_i),
    .rsp_data_i  (mem_rsp_data_i),
    .rd_idx_i    (head_idx),
    .rd_filled_o (head_filled),
    .rd_tag_o    (fetch_addr_o),
    .rd_data_o   (fetch_data_o)
  );

  opq_order_queue #(.DEPTH(MAX_LEAD), .W(LINE_W)) u_order (
    .clk_i, .rst_ni, .clear_i,
    .push_i  (push),
    .din_i   (take_merge ? hit_idx : free_idx),
    .pop_i   (pop),
    .dout_o  (head_idx),
    .empty_o (q_empty),
    .count_o (q_count)
  );

  // one miss per head entry that waits on its fill with the consumer ready
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_q    <= '0;
      counted_q <= 1'b0;
    end else if (clear_i) begin
      miss_q    <= '0;
      counted_q <= 1'b0;
    end else if (pop) begin
      counted_q <= 1'b0;
    end else if (!q_empty && !head_filled && fetch_ready_i && !counted_q) begin
      miss_q    <= miss_q + MISS_W'(1);
      counted_q <= 1'b1;
    end
  end

  assign miss_count_o = miss_q;

  AST_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_o && !fetch_ready_i && !clear_i) |=>
    (clear_i || (fetch_valid_o && $stable(fetch_addr_o) && $stable(fetch_data_o)))); // R10
  AST_MISS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(miss_count_o) |-> (miss_count_o == '0 || miss_count_o == $past(miss_count_o) + MISS_W'(1))); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !fetch_valid_o && (miss_count_o == '0)); // R11
endmodule

// File: tb/opq_cache_test.sv
`timescale 1ns/1ps
module opq_cache_test;
  localparam int ADDR_W = 16, DATA_W = 32, LINES = 6, MAX_LEAD = 8, MISS_W = 16;
  localparam int LINE_W = $clog2(LINES);
  localparam int LEAD_W = $clog2(MAX_LEAD + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0, clear_i = 1'b0;
  logic [LEAD_W-1:0] lead_i = '0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic mem_req_valid_o, mem_req_ready_i = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr_o;
  logic [LINE_W-1:0] mem_req_line_o;
  logic mem_rsp_valid_i = 1'b0;
  logic [LINE_W-1:0] mem_rsp_line_i = '0;
  logic [DATA_W-1:0] mem_rsp_data_i = '0;
  logic fetch_valid_o, fetch_ready_i = 1'b0;
  logic [ADDR_W-1:0] fetch_addr_o;
  logic [DATA_W-1:0] fetch_data_o;
  logic [MISS_W-1:0] miss_count_o;

  always #2 clk_i = ~clk_i;

  opq_cache uut (.*);

  int checks = 0, failures = 0, cyc = 0;
  int stim[$];
  int lead_v = 0, frdy_pct = 0, mrdy_pct = 100, rsp_pct = 100;
  bit clear_req = 0;
  typedef struct { int line; int addr; bit stale; } ost_t;
  ost_t ost[$];
  bit rsp_stale = 0;
  int rsp_addr = 0;
  int mq[$];
  int held[int];
  bit filled[int];
  int line_of[int];
  int miss_m = 0, reads = 0;
  bit counted_m = 0, prev_stall = 0;
  int prev_addr = 0;

  function automatic logic [DATA_W-1:0] dat(input int a);
    return DATA_W'(a) * 32'h9E37_79B1 ^ 32'hA5A5_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // driver: inputs change 1 ns after the rising edge
  always begin
    @(posedge clk_i); #1;
    req_valid_i     = stim.size() > 0;
    req_addr_i      = stim.size() > 0 ? ADDR_W'(stim[0]) : '0;
    lead_i          = LEAD_W'(lead_v);
    fetch_ready_i   = ($urandom % 100) < frdy_pct;
    mem_req_ready_i = ($urandom % 100) < mrdy_pct;
    clear_i         = clear_req;
    clear_req       = 0;
    mem_rsp_valid_i = 1'b0;
    if (ost.size() > 0 && ($urandom % 100) < rsp_pct) begin
      int k;
      k = $urandom % ost.size();
      mem_rsp_valid_i = 1'b1;
      mem_rsp_line_i  = LINE_W'(ost[k].line);
      mem_rsp_data_i  = dat(ost[k].addr);
      rsp_stale       = ost[k].stale;
      rsp_addr        = ost[k].addr;
      ost.delete(k);
    end
  end

  // reference model, compared on every falling edge
  always @(negedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      report();
    end
    if (rst_ni) begin
      int used, eff, a;
      bit room, hit, hf, exp_rr, exp_mv, exp_fv;
      used = held.num() + ((mem_rsp_valid_i && rsp_stale) ? 1 : 0);
      foreach (ost[i]) if (ost[i].stale) used++;
      eff  = lead_v > MAX_LEAD ? MAX_LEAD : lead_v;
      room = mq.size() < eff && !clear_i;
      hit  = req_valid_i && held.exists(int'(req_addr_i));
      hf   = mq.size() > 0 && filled.exists(mq[0]) && filled[mq[0]];
      exp_rr = room && (hit || (used < LINES && mem_req_ready_i));
      exp_mv = req_valid_i && room && !hit && used < LINES;
      exp_fv = !clear_i && hf;
      if (req_valid_i)
        chk(req_ready_o == exp_rr, !room ? "R5" : (hit ? "R4" : "R6"), req_ready_o, exp_rr);
      chk(mem_req_valid_o == exp_mv, hit ? "R4" : "R3", mem_req_valid_o, exp_mv);
      if (exp_mv && mem_req_valid_o)
        chk(mem_req_addr_o == req_addr_i, "R3", mem_req_addr_o, req_addr_i);
      chk(fetch_valid_o == exp_fv, clear_i ? "R1" : "R8", fetch_valid_o, exp_fv);
      if (exp_fv && fetch_valid_o) begin
        chk(int'(fetch_addr_o) == mq[0], prev_stall ? "R10" : "R2", fetch_addr_o, mq[0]);
        chk(fetch_data_o == dat(mq[0]), "R2", fetch_data_o, dat(mq[0]));
      end
      chk(int'(miss_count_o) == miss_m, "R9", miss_count_o, miss_m);
      prev_stall = fetch_valid_o && !fetch_ready_i;
      prev_addr  = int'(fetch_addr_o);

      if (clear_i) begin
        foreach (ost[i]) ost[i].stale = 1;
        held.delete(); filled.delete(); line_of.delete(); mq.delete();
        miss_m = 0; counted_m = 0; prev_stall = 0;
      end else begin
        if (mq.size() > 0 && !hf && fetch_ready_i && !counted_m) begin
          miss_m++; counted_m = 1;
        end
        if (mem_rsp_valid_i && !rsp_stale && held.exists(rsp_addr)) filled[rsp_addr] = 1;
        if (req_valid_i && req_ready_o) begin
          a = int'(req_addr_i);
          if (held.exists(a)) held[a]++;
          else begin held[a] = 1; filled[a] = 0; end
          mq.push_back(a);
          void'(stim.pop_front());
        end
        if (mem_req_valid_o && mem_req_ready_i) begin
          bit clash;
          clash = 0;
          foreach (ost[i]) if (ost[i].line == int'(mem_req_line_o)) clash = 1;
          foreach (line_of[k]) if (k != int'(mem_req_addr_o) && held.exists(k) &&
                                   line_of[k] == int'(mem_req_line_o)) clash = 1;
          chk(!clash, "R11", mem_req_line_o, -1);
          ost.push_back('{int'(mem_req_line_o), int'(mem_req_addr_o), 1'b0});
          line_of[int'(mem_req_addr_o)] = int'(mem_req_line_o);
          reads++;
        end
        if (fetch_valid_o && fetch_ready_i && mq.size() > 0) begin
          a = mq.pop_front();
          held[a]--;
          if (held[a] == 0) begin held.delete(a); filled.delete(a); end
          counted_m = 0;
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #3;
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && (stim.size() > 0 || mq.size() > 0); i++) step(1);
  endtask

  initial begin
    int m0;
    step(3);
    rst_ni = 1'b1;
    step(1);
    chk(fetch_valid_o == 1'b0, "R1", fetch_valid_o, 0);
    chk(miss_count_o == '0, "R1", miss_count_o, 0);
    chk(mem_req_valid_o == 1'b0, "R1", mem_req_valid_o, 0);

    // lead 0 blocks everything
    stim = '{3, 4};
    step(10);
    chk(stim.size() == 2, "R5", stim.size(), 2);

    // merge: repeated address inside the window shares one read
    lead_v = 8; frdy_pct = 0; reads = 0;
    stim = '{5, 5, 5, 7, 5};
    step(30);
    chk(reads == 2, "R4", reads, 2);
    frdy_pct = 100; drain();

    // release then re-request: lead 1 forces consumption between uses
    lead_v = 1; reads = 0;
    stim = '{9, 9, 9};
    drain(); step(5);
    chk(reads == 3, "R7", reads, 3);

    // free-line limit: more distinct addresses than lines, consumer stalled
    lead_v = 12; frdy_pct = 0; reads = 0;
    stim = '{20, 21, 22, 23, 24, 25, 26, 27, 28, 29};
    step(40);
    chk(reads == LINES, "R6", reads, LINES);
    chk(stim.size() == 10 - LINES, "R6", stim.size(), 10 - LINES);
    frdy_pct = 100; drain();

    // miss counted once while waiting on a fill
    lead_v = 1; rsp_pct = 0; m0 = int'(miss_count_o);
    stim = '{40};
    step(12);
    chk(int'(miss_count_o) == m0 + 1, "R9", miss_count_o, m0 + 1);
    rsp_pct = 100; drain();

    // clear with reads in flight
    lead_v = 8; rsp_pct = 0; frdy_pct = 0;
    stim = '{50, 51, 52, 50};
    step(10);
    clear_req = 1;
    step(1);
    step(1);
    chk(fetch_valid_o == 1'b0, "R11", fetch_valid_o, 0);
    chk(miss_count_o == '0, "R11", miss_count_o, 0);
    stim = '{50, 60, 61};
    rsp_pct = 30; frdy_pct = 100;
    drain(); step(20);

    // random out-of-order traffic
    rsp_pct = 40; frdy_pct = 60; mrdy_pct = 70;
    for (int r = 0; r < 6; r++) begin
      lead_v = 1 + (r * 3) % 10;
      for (int i = 0; i < 60; i++) stim.push_back($urandom % 12);
      drain();
    end
    frdy_pct = 100; rsp_pct = 100;
    drain(); step(20);
    report();
  end
endmodule